// File: doc/BRIEF.md
# Isochronous IN Byte Accumulator with Babble Check

This block follows the data phase of one micro-frame on a high-bandwidth isochronous IN endpoint. A start pulse arms it with a transaction count of one to three. It then counts the bytes of each incoming packet, presented as a byte-valid strobe with an end-of-packet marker. When each packet ends, the block adds that packet's byte count to a running length. Once the last permitted packet has ended, the length output holds the total number of bytes received in the micro-frame.

Each packet is checked against a per-packet limit. The limit is the smaller of two values: the maximum packet size, and the allowance still unused. The unused allowance is the allowed total minus the bytes already committed. If a byte arrives beyond that limit, the block stops the micro-frame and raises a sticky babble flag.

A packet shorter than the limit is normal and raises nothing. The transaction count, maximum packet size and allowed total must be held stable while the block is active.

Top module: `iso_in_accum`

## Requirements
- R1: After reset, active_o, babble_o and done_o are 0 and len_o is 0.
- R2: A start_i pulse with mult_i of 1, 2 or 3 while idle makes active_o 1 in the next cycle and clears len_o and babble_o. A start_i with mult_i = 0, or any start_i while active, is ignored.
- R3: While active, every cycle with byte_vld_i = 1 counts one byte of the current packet, including a byte in the same cycle as eop_i. A cycle with eop_i = 1 ends the packet. eop_i alone ends a zero-length packet. At the end of a packet its byte count is added to len_o, which is 12 bits wide, so 3072 is reachable.
- R4: After the packet numbered mult_i ends, active_o is 0 and len_o holds the micro-frame total. done_o is 1 for exactly the one cycle that follows the cycle of that final eop_i.
- R5: The per-packet limit is min(allowed total − len_o so far, max_pkt_i). The first byte beyond the limit sets babble_o, clears active_o and yields the one-cycle done_o pulse in the next cycle. This holds even when that byte carries eop_i. len_o then excludes the offending packet, and the remaining transactions are abandoned.
- R6: A packet that ends exactly at its limit, or below it (including zero length), does not set babble_o and does not end the micro-frame early.
- R7: byte_vld_i and eop_i while not active have no effect on len_o, babble_o or done_o.
- R8: babble_o stays set after a babble abort until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a micro-frame |
| mult_i | input | 2 | Number of transactions (1..3) |
| max_pkt_i | input | 11 | Maximum packet size in bytes |
| alloc_len_i | input | 12 | Allowed total bytes for the micro-frame |
| byte_vld_i | input | 1 | One received byte this cycle |
| eop_i | input | 1 | End of the current packet |
| active_o | output | 1 | Micro-frame in progress |
| len_o | output | 12 | Sum of bytes of completed packets |
| babble_o | output | 1 | Packet exceeded its limit (sticky) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can coincide in a single cycle: the byte that exceeds the packet limit and the end-of-packet marker. The same holds for the byte that exactly reaches the limit and that marker. The bench drives both cases directly. The random frames also produce them, because packet lengths are drawn around the limit and the marker is placed sometimes on the last byte and sometimes in a cycle of its own. In the coinciding case, the bench expects the overrun to take precedence: babble is set, the length excludes the packet, and done follows that cycle. An exact-limit packet ending on its marker must instead commit its bytes with no babble.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
  localparam int unsigned LEN_W_DEF  = 12;
  localparam int unsigned MPS_W_DEF  = 11;
  localparam int unsigned MULT_W_DEF = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/iso_in_limit.sv
module iso_in_limit #(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned MPS_W = 11
) (
  input  logic [LEN_W-1:0] alloc_len_i,
  input  logic [LEN_W-1:0] sum_i,
  input  logic [MPS_W-1:0] max_pkt_i,
  output logic [LEN_W-1:0] limit_o
);
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] mps_ext;

  always_comb begin
    rem     = (alloc_len_i > sum_i) ? (alloc_len_i - sum_i) : '0;
    mps_ext = LEN_W'(max_pkt_i);
    limit_o = (rem < mps_ext) ? rem : mps_ext;
  end
endmodule

// File: rtl/iso_in_pkt_cnt.sv
module iso_in_pkt_cnt #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             byte_vld_i,
  input  logic             eop_i,
  input  logic [LEN_W-1:0] limit_i,
  output logic             overrun_o,
  output logic             pkt_end_o,
  output logic [LEN_W-1:0] pkt_bytes_o
);
  logic [LEN_W-1:0] cnt_q;

  // overrun has priority over an end-of-packet in the same cycle
  always_comb begin
    overrun_o   = en_i & byte_vld_i & (cnt_q >= limit_i);
    pkt_end_o   = en_i & eop_i & ~overrun_o;
    pkt_bytes_o = cnt_q + LEN_W'(byte_vld_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || overrun_o || pkt_end_o) begin
      cnt_q <= '0;
    end else if (en_i && byte_vld_i) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/iso_in_seq.sv
module iso_in_seq
  import iso_in_pkg::*;
#(
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned MULT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              overrun_i,
  input  logic              pkt_end_i,
  input  logic [LEN_W-1:0]  pkt_bytes_i,
  output logic              start_ok_o,
  output logic              active_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              babble_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [MULT_W-1:0] left_q;
  logic [LEN_W-1:0]  len_q;
  logic              babble_q;
  logic              done_q;

  assign start_ok_o = (state_q == SEQ_IDLE) && start_i && (mult_i != '0);
  assign active_o   = (state_q == SEQ_RUN);
  assign len_o      = len_q;
  assign babble_o   = babble_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      left_q   <= '0;
      len_q    <= '0;
      babble_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start_ok_o) begin
            state_q  <= SEQ_RUN;
            left_q   <= mult_i;
            len_q    <= '0;
            babble_q <= 1'b0;
          end
        end
        SEQ_RUN: begin
          if (overrun_i) begin
            // abandon remaining transactions, keep committed sum
            state_q  <= SEQ_IDLE;
            babble_q <= 1'b1;
            done_q   <= 1'b1;
          end else if (pkt_end_i) begin
            len_q  <= len_q + pkt_bytes_i;
            left_q <= left_q - MULT_W'(1);
            if (left_q == MULT_W'(1)) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iso_in_accum.sv
module iso_in_accum
  import iso_in_pkg::*;
#(
  parameter int unsigned LEN_W  = LEN_W_DEF,
  parameter int unsigned MPS_W  = MPS_W_DEF,
  parameter int unsigned MULT_W = MULT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [MPS_W-1:0]  max_pkt_i,
  input  logic [LEN_W-1:0]  alloc_len_i,
  input  logic              byte_vld_i,
  input  logic              eop_i,
  output logic              active_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              babble_o,
  output logic              done_o
);
  logic [LEN_W-1:0] limit;
  logic [LEN_W-1:0] pkt_bytes;
  logic             overrun;
  logic             pkt_end;
  logic             start_ok;

  iso_in_limit #(.LEN_W(LEN_W), .MPS_W(MPS_W)) i_limit (
    .alloc_len_i (alloc_len_i),
    .sum_i       (len_o),
    .max_pkt_i   (max_pkt_i),
    .limit_o     (limit)
  );

  iso_in_pkt_cnt #(.LEN_W(LEN_W)) i_pkt_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_ok),
    .en_i        (active_o),
    .byte_vld_i  (byte_vld_i),
    .eop_i       (eop_i),
    .limit_i     (limit),
    .overrun_o   (overrun),
    .pkt_end_o   (pkt_end),
    .pkt_bytes_o (pkt_bytes)
  );

  iso_in_seq #(.LEN_W(LEN_W), .MULT_W(MULT_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mult_i      (mult_i),
    .overrun_i   (overrun),
    .pkt_end_i   (pkt_end),
    .pkt_bytes_i (pkt_bytes),
    .start_ok_o  (start_ok),
    .active_o    (active_o),
    .len_o       (len_o),
    .babble_o    (babble_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/iso_in_accum_chk.sv
module iso_in_accum_chk #(
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned MULT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [MULT_W-1:0] mult_i,
  input logic [LEN_W-1:0]  alloc_len_i,
  input logic              active_o,
  input logic [LEN_W-1:0]  len_o,
  input logic              babble_o,
  input logic              done_o
);
  // R2
  zero_mult_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && start_i && mult_i == '0) |=> !active_o);

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_ends_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!active_o && $past(active_o)));

  // R5
  babble_aborts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(babble_o) |-> $fell(active_o));

  // R5
  len_in_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (len_o <= alloc_len_i));

  // R7
  idle_len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> $stable(len_o));

  // R8
  babble_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> $stable(babble_o));
endmodule

bind iso_in_accum iso_in_accum_chk #(.LEN_W(LEN_W), .MULT_W(MULT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mult_i      (mult_i),
  .alloc_len_i (alloc_len_i),
  .active_o    (active_o),
  .len_o       (len_o),
  .babble_o    (babble_o),
  .done_o      (done_o)
);

// File: tb/test_iso_in_accum.sv
module test_iso_in_accum;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mult_i = '0;
  logic [10:0] max_pkt_i = '0;
  logic [11:0] alloc_len_i = '0;
  logic        byte_vld_i = 1'b0;
  logic        eop_i = 1'b0;
  logic        active_o;
  logic [11:0] len_o;
  logic        babble_o;
  logic        done_o;

  int checks = 0;
  int fails = 0;
  int dmis = 0;
  int dseen = 0;
  int plen [3];
  bit sep = 1'b0;
  int gap_pct = 0;

  always #4 clk_i = ~clk_i;

  iso_in_accum i_iso_in_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mult_i(mult_i),
    .max_pkt_i(max_pkt_i), .alloc_len_i(alloc_len_i), .byte_vld_i(byte_vld_i),
    .eop_i(eop_i), .active_o(active_o), .len_o(len_o), .babble_o(babble_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle; term = done_o expected in the following cycle
  task automatic cyc(input bit v, input bit e, input bit term);
    byte_vld_i = v;
    eop_i = e;
    @(negedge clk_i);
    if (done_o !== term) dmis++;
    if (done_o === 1'b1) dseen++;
    byte_vld_i = 1'b0;
    eop_i = 1'b0;
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic frame(input int m, input int mps, input int alloc);
    int exp_sum = 0;
    bit exp_bab = 1'b0;
    int s = 0;
    bit ab = 1'b0;
    for (int p = 0; p < m; p++) begin
      if (!exp_bab) begin
        if (plen[p] > min2(alloc - exp_sum, mps)) exp_bab = 1'b1;
        else exp_sum += plen[p];
      end
    end
    mult_i = 2'(m); max_pkt_i = 11'(mps); alloc_len_i = 12'(alloc);
    dmis = 0; dseen = 0;
    start_i = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    start_i = 1'b0;
    chk(active_o === 1'b1, "R2 active after start", int'(active_o), 1);
    chk(len_o === '0 && babble_o === 1'b0, "R2 len/babble cleared", int'(len_o) + int'(babble_o), 0);
    for (int p = 0; p < m; p++) begin
      int lim = min2(alloc - s, mps);
      for (int b = 0; b < plen[p]; b++) begin
        bit last = (b == plen[p] - 1) && !sep;
        bit term;
        if (($urandom % 100) < gap_pct) cyc(1'b0, 1'b0, 1'b0);
        term = !ab && ((b == lim) || (last && p == m - 1));
        cyc(1'b1, last, term);
        if (!ab && b == lim) ab = 1'b1;
      end
      if (plen[p] == 0 || sep) cyc(1'b0, 1'b1, !ab && (p == m - 1));
      if (!ab) s += plen[p];
    end
    cyc(1'b0, 1'b0, 1'b0);
    // R7: stray traffic after the frame
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    chk(len_o == 12'(exp_sum), "R3/R7 len total", int'(len_o), exp_sum);
    chk(babble_o === exp_bab, "R5/R6 babble", int'(babble_o), int'(exp_bab));
    chk(active_o === 1'b0, "R4 inactive at end", int'(active_o), 0);
    chk(dmis == 0 && dseen == 1, "R4 done pulse timing", dseen + 100 * dmis, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1
    chk(active_o === 1'b0 && babble_o === 1'b0 && done_o === 1'b0 && len_o === '0,
        "R1 reset state", int'(active_o) + int'(babble_o) + int'(done_o) + int'(len_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: mult 0 ignored
    mult_i = 2'd0; max_pkt_i = 11'd8; alloc_len_i = 12'd8;
    start_i = 1'b1;
    dmis = 0; dseen = 0;
    cyc(1'b0, 1'b0, 1'b0);
    start_i = 1'b0;
    chk(active_o === 1'b0, "R2 mult zero ignored", int'(active_o), 0);
    cyc(1'b1, 1'b1, 1'b0);
    chk(len_o == 0 && dseen == 0, "R7 idle bytes ignored", int'(len_o) + dseen, 0);

    // R6: exact limit, eop on last byte
    sep = 1'b0; plen[0] = 8; plen[1] = 8; frame(2, 8, 16);
    // R5: overrun byte carries eop
    plen[0] = 9; frame(1, 8, 8);
    // R8: babble holds while idle
    repeat (4) cyc(1'b0, 1'b0, 1'b0);
    chk(babble_o === 1'b1, "R8 babble sticky", int'(babble_o), 1);
    // R5: limit from remaining allowance; R6 zero-length at limit 0
    plen[0] = 10; plen[1] = 5; plen[2] = 0; frame(3, 10, 15);
    chk(babble_o === 1'b0, "R8 babble cleared by start", int'(babble_o), 0);
    plen[0] = 10; plen[1] = 6; plen[2] = 1; frame(3, 10, 15);
    // R6: short packets, separate eop
    sep = 1'b1; plen[0] = 3; plen[1] = 0; plen[2] = 7; frame(3, 16, 48);
    // R3: full 3072-byte micro-frame
    sep = 1'b0; plen[0] = 1024; plen[1] = 1024; plen[2] = 1024; frame(3, 1024, 3072);

    // R2: start while active ignored
    mult_i = 2'd2; max_pkt_i = 11'd4; alloc_len_i = 12'd8;
    dmis = 0; dseen = 0;
    start_i = 1'b1; cyc(1'b0, 1'b0, 1'b0); start_i = 1'b0;
    cyc(1'b1, 1'b0, 1'b0); cyc(1'b1, 1'b1, 1'b0);
    mult_i = 2'd1; start_i = 1'b1; cyc(1'b0, 1'b0, 1'b0); start_i = 1'b0;
    chk(active_o === 1'b1 && len_o == 2, "R2 restart ignored", int'(len_o), 2);
    cyc(1'b1, 1'b0, 1'b0); cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    chk(len_o == 4 && dseen == 1 && dmis == 0, "R4 original count kept", int'(len_o), 4);

    // random frames
    gap_pct = 20;
    for (int f = 0; f < 60; f++) begin
      int m = 1 + int'($urandom % 3);
      int mps = 1 + int'($urandom % 48);
      int alloc = int'($urandom % (m * mps + 8));
      sep = 1'($urandom % 2);
      for (int p = 0; p < 3; p++) plen[p] = int'($urandom % (mps + 3));
      frame(m, mps, alloc);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule